// File: doc/BRIEF.md
# EPP Parallel Port Cycle Controller

This block runs a printer-style parallel port from a host I/O bus. The host reads and writes five byte registers at a selectable base address: a data latch, a status view of the peripheral's input lines, a control register, an EPP address port and an EPP data port. In compatibility mode the control register bits drive the printer's output lines directly. In EPP mode three of those lines are instead used as a write indicator, a data strobe and an address strobe. Every host access to an EPP port becomes a timed bus cycle on the cable.

An EPP cycle asserts its strobe for a fixed minimum number of clock cycles. If the peripheral's busy line is still high at the end of that time, the strobe is stretched until busy drops or a timeout count expires. After the strobe is released, a recovery period must pass before the next strobe. While a cycle or a recovery period is in progress, any host access to the port is held off with a not-ready signal. The external data buffer drives toward the cable only during EPP write cycles.

The cycle sequencer has six states:
- IDLE: waiting for a request.
- SETUP: write only; the write indicator and buffer come on one cycle ahead of the strobe.
- STROBE: the nominal strobe width.
- WAIT: the busy-driven stretch.
- DONE: the strobe is off and the host access completes.
- RECOVER: the recovery gap.

Its transitions are:
- IDLE→SETUP on an EPP write request.
- IDLE→STROBE on an EPP read request.
- SETUP→STROBE after one cycle.
- STROBE→DONE at the end of the nominal width with busy low.
- STROBE→WAIT at the end of the nominal width with busy high.
- WAIT→DONE on busy low or timeout.
- DONE→RECOVER after one cycle.
- RECOVER→IDLE when the gap has elapsed.

Top module: `epp_port_ctrl`

## Requirements
- R1: After reset, prn_write_n, prn_data_stb_n, prn_addr_stb_n and prn_init_n are all high, buf_oe_n is high, buf_dir is 0, and hst_rdy is high with no access pending.
- R2: cfg_base_sel selects the port base: 1 = 3BCh, 2 = 378h, 3 = 278h, 0 = disabled. Register offsets from the base are 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data. An address outside the five offsets, or any address while disabled, gets hst_rdy high and hst_rdata 0, and changes no register.
- R3: The data and control registers read back what was written (control bits [3:0], upper bits read 0). With cfg_epp_en low, control bit 0 drives prn_write_n, bit 1 drives prn_data_stb_n and bit 3 drives prn_addr_stb_n, each pin low when its bit is 1. Control bit 2 drives prn_init_n low in either mode. A status read returns {prn_busy, prn_ack_n, prn_paper_out, prn_online, prn_fault_n, 2'b00, timeout} in bits 7 down to 0.
- R4: An EPP data write drives prn_write_n low one cycle before prn_data_stb_n goes low. pd_out carries the written byte. With prn_busy low, the data strobe stays low for exactly STRB_CYC cycles, and the access completes after STRB_CYC+2 not-ready cycles.
- R5: An EPP address access uses prn_addr_stb_n with the same timing as a data access, and prn_data_stb_n stays high.
- R6: An EPP data read keeps prn_write_n high and returns the pd_in value sampled when the strobe ends, completing after STRB_CYC+1 not-ready cycles.
- R7: buf_oe_n is low and buf_dir is 1 only during EPP write cycles, from the setup cycle through the completion cycle. At all other times buf_oe_n is high and buf_dir is 0.
- R8: If prn_busy is high at the end of the nominal width, the strobe stays low until the cycle after prn_busy is seen low.
- R9: If prn_busy stays high for TMO_CYC cycles past the nominal width, the strobe is released after STRB_CYC+TMO_CYC cycles and status bit 0 is set. That bit stays set until a status read completes, which clears it.
- R10: Between two EPP strobes at least REC_CYC strobe-free cycles pass. A host access to the port made during a strobe or during recovery sees hst_rdy low, and an access issued in the first recovery cycle waits exactly REC_CYC cycles.
- R11: With cfg_epp_en low, accesses to offsets 3 and 4 complete at once, start no strobe, leave the buffer off and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_sel | input | 2 | Base address select (0 disables the port) |
| cfg_epp_en | input | 1 | 1 = EPP strobe mode, 0 = compatibility pass-through |
| hst_addr | input | ADDR_W | Host I/O address |
| hst_rd | input | 1 | Host read request, held until hst_rdy |
| hst_wr | input | 1 | Host write request, held until hst_rdy |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid while hst_rdy is high |
| hst_rdy | output | 1 | Access completes on a clock edge where this is high |
| pd_in | input | 8 | Data from the external buffer (cable side) |
| pd_out | output | 8 | Data toward the external latch |
| buf_oe_n | output | 1 | External buffer output enable, active low |
| buf_dir | output | 1 | Buffer direction, 1 = toward peripheral |
| prn_busy | input | 1 | Peripheral busy / wait line |
| prn_ack_n | input | 1 | Peripheral acknowledge line |
| prn_paper_out | input | 1 | Peripheral paper-out line |
| prn_online | input | 1 | Peripheral selected line |
| prn_fault_n | input | 1 | Peripheral fault line |
| prn_write_n | output | 1 | Strobe line / EPP write indicator |
| prn_data_stb_n | output | 1 | Autofeed line / EPP data strobe |
| prn_addr_stb_n | output | 1 | Select-in line / EPP address strobe |
| prn_init_n | output | 1 | Initialize line |

## Verification
The assertions assume that cfg_epp_en and cfg_base_sel stay constant while a cycle or recovery is in progress. They also assume that a host request, once raised, is held with the same address and data until hst_rdy is seen high. The stimulus changes configuration only after letting the port go idle. Each access is issued from a task that keeps the request steady until the completing edge and drops it just after. The busy line is moved only at falling clock edges, so the cycle in which the sequencer sees it is exact.

// File: rtl/epp_port_pkg.sv
package epp_port_pkg;

    localparam int DATA_W   = 8;
    localparam int OFS_W    = 3;
    localparam int NUM_REGS = 5;
    localparam int CTRL_W   = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_STAT  = 3'd1,
        OFS_CTRL  = 3'd2,
        OFS_EADDR = 3'd3,
        OFS_EDATA = 3'd4
    } reg_ofs_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_DONE,
        ST_RECOVER
    } cyc_state_e;

    typedef enum logic [1:0] {
        BASE_OFF = 2'd0,
        BASE_HI  = 2'd1,
        BASE_MID = 2'd2,
        BASE_LO  = 2'd3
    } base_sel_e;

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic paper_out;
        logic online;
        logic fault_n;
    } pin_status_t;

endpackage

// File: rtl/epp_addr_decode.sv
module epp_addr_decode
    import epp_port_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_HI_AD  = 'h3BC,
    parameter logic [ADDR_W-1:0] BASE_MID_AD = 'h378,
    parameter logic [ADDR_W-1:0] BASE_LO_AD  = 'h278
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        base_sel_i,
    output logic              hit_o,
    output reg_ofs_e          ofs_o
);

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] delta;

    always_comb begin
        unique case (base_sel_e'(base_sel_i))
            BASE_HI:  base_addr = BASE_HI_AD;
            BASE_MID: base_addr = BASE_MID_AD;
            BASE_LO:  base_addr = BASE_LO_AD;
            default:  base_addr = '0;
        endcase
        delta = addr_i - base_addr;
        hit_o = (base_sel_e'(base_sel_i) != BASE_OFF) && (delta < ADDR_W'(NUM_REGS));
        ofs_o = reg_ofs_e'(delta[OFS_W-1:0]);
    end

endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_port_pkg::*;
#(
    parameter int STRB_CYC = 45,
    parameter int REC_CYC  = 100,
    parameter int TMO_CYC  = 500
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              start_wr_i,
    input  logic              start_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] pd_i,
    output logic              idle_o,
    output logic              done_o,
    output logic              wr_act_o,
    output logic              dstb_o,
    output logic              astb_o,
    output logic              drive_o,
    output logic [DATA_W-1:0] pd_o,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              tmo_set_o
);

    localparam int MAX_AB  = (STRB_CYC > REC_CYC) ? STRB_CYC : REC_CYC;
    localparam int CNT_MAX = (MAX_AB > TMO_CYC) ? MAX_AB : TMO_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);

    cyc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_wr_q, is_addr_q;
    logic [DATA_W-1:0] pd_q, rd_q;
    logic              stb_on, strobe_end, tmo_hit;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = start_wr_i ? ST_SETUP : ST_STROBE;
            ST_SETUP:   state_d = ST_STROBE;
            ST_STROBE:  if (cnt_q == STRB_LAST) state_d = busy_i ? ST_WAIT : ST_DONE;
            ST_WAIT:    if (!busy_i || cnt_q == TMO_LAST) state_d = ST_DONE;
            ST_DONE:    state_d = ST_RECOVER;
            ST_RECOVER: if (cnt_q == REC_LAST) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign strobe_end = (state_q inside {ST_STROBE, ST_WAIT}) && (state_d == ST_DONE);
    assign tmo_hit    = (state_q == ST_WAIT) && busy_i && (cnt_q == TMO_LAST);

    // phase counter and cycle context
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            is_wr_q   <= 1'b0;
            is_addr_q <= 1'b0;
            pd_q      <= '0;
            rd_q      <= '0;
        end else begin
            if (state_d != state_q || state_q == ST_IDLE) cnt_q <= '0;
            else                                        cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_IDLE && start_i) begin
                is_wr_q   <= start_wr_i;
                is_addr_q <= start_addr_i;
                if (start_wr_i) pd_q <= wdata_i;
            end
            if (strobe_end && !is_wr_q) rd_q <= pd_i;
        end
    end

    // outputs
    always_comb begin
        stb_on    = (state_q == ST_STROBE) || (state_q == ST_WAIT);
        idle_o    = (state_q == ST_IDLE);
        done_o    = (state_q == ST_DONE);
        wr_act_o  = is_wr_q && (state_q inside {ST_SETUP, ST_STROBE, ST_WAIT, ST_DONE});
        dstb_o    = stb_on && !is_addr_q;
        astb_o    = stb_on && is_addr_q;
        drive_o   = wr_act_o;
        pd_o      = pd_q;
        rd_byte_o = rd_q;
        tmo_set_o = tmo_hit;
    end

    // R8
    busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stb_on) |-> (!$past(busy_i) || $past(tmo_hit)));

endmodule

// File: rtl/epp_reg_file.sv
module epp_reg_file
    import epp_port_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              epp_mode_i,
    input  logic              wr_acc_i,
    input  logic              rd_acc_i,
    input  reg_ofs_e          ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  pin_status_t       pins_i,
    input  logic              tmo_set_i,
    input  logic [DATA_W-1:0] epp_byte_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              tmo_o
);

    logic [DATA_W-1:0] data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              tmo_q;
    logic              stat_rd;

    assign stat_rd = rd_acc_i && (ofs_i == OFS_STAT);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            data_q <= '0;
            ctrl_q <= '0;
            tmo_q  <= 1'b0;
        end else begin
            if (wr_acc_i && ofs_i == OFS_DATA) data_q <= wdata_i;
            if (wr_acc_i && ofs_i == OFS_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (tmo_set_i)    tmo_q <= 1'b1;
            else if (stat_rd) tmo_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (ofs_i)
            OFS_DATA:  rdata_o = data_q;
            OFS_STAT:  rdata_o = {pins_i.busy, pins_i.ack_n, pins_i.paper_out,
                                  pins_i.online, pins_i.fault_n, 2'b00, tmo_q};
            OFS_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_EADDR,
            OFS_EDATA: rdata_o = epp_mode_i ? epp_byte_i : '0;
            default:   rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign tmo_o  = tmo_q;

    // R9
    tmo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmo_q && !stat_rd) |=> tmo_q);

endmodule

// File: rtl/epp_port_ctrl.sv
module epp_port_ctrl
    import epp_port_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_HI_AD  = 'h3BC,
    parameter logic [ADDR_W-1:0] BASE_MID_AD = 'h378,
    parameter logic [ADDR_W-1:0] BASE_LO_AD  = 'h278,
    parameter int                STRB_CYC    = 45,
    parameter int                REC_CYC     = 100,
    parameter int                TMO_CYC     = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_base_sel,
    input  logic              cfg_epp_en,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic [7:0]        hst_wdata,
    output logic [7:0]        hst_rdata,
    output logic              hst_rdy,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              buf_oe_n,
    output logic              buf_dir,
    input  logic              prn_busy,
    input  logic              prn_ack_n,
    input  logic              prn_paper_out,
    input  logic              prn_online,
    input  logic              prn_fault_n,
    output logic              prn_write_n,
    output logic              prn_data_stb_n,
    output logic              prn_addr_stb_n,
    output logic              prn_init_n
);

    localparam int RUN_W = $clog2(STRB_CYC + 1);
    localparam int GAP_W = $clog2(REC_CYC + 1);

    logic              hit, acc, epp_ofs, epp_req, start;
    reg_ofs_e          ofs;
    logic              f_idle, f_done, f_wr, f_dstb, f_astb, f_drive, f_tmo;
    logic [DATA_W-1:0] f_pd, f_rd, rf_rdata;
    logic [CTRL_W-1:0] ctrl;
    logic              tmo_flag, wr_acc, rd_acc;
    pin_status_t       pins;

    epp_addr_decode #(
        .ADDR_W(ADDR_W), .BASE_HI_AD(BASE_HI_AD),
        .BASE_MID_AD(BASE_MID_AD), .BASE_LO_AD(BASE_LO_AD)
    ) u_dec (
        .addr_i(hst_addr), .base_sel_i(cfg_base_sel), .hit_o(hit), .ofs_o(ofs)
    );

    always_comb begin
        acc     = hst_rd || hst_wr;
        epp_ofs = (ofs == OFS_EADDR) || (ofs == OFS_EDATA);
        epp_req = hit && acc && epp_ofs && cfg_epp_en;
        start   = epp_req && f_idle;
        if (!hit || !acc) hst_rdy = 1'b1;
        else if (f_idle)  hst_rdy = !epp_req;
        else if (f_done)  hst_rdy = epp_req;
        else              hst_rdy = 1'b0;
        wr_acc  = hit && hst_wr && hst_rdy && !epp_req;
        rd_acc  = hit && hst_rd && hst_rdy && !epp_req;
    end

    epp_cycle_fsm #(
        .STRB_CYC(STRB_CYC), .REC_CYC(REC_CYC), .TMO_CYC(TMO_CYC)
    ) u_fsm (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_wr_i(hst_wr),
        .start_addr_i(ofs == OFS_EADDR), .wdata_i(hst_wdata), .busy_i(prn_busy),
        .pd_i(pd_in), .idle_o(f_idle), .done_o(f_done), .wr_act_o(f_wr),
        .dstb_o(f_dstb), .astb_o(f_astb), .drive_o(f_drive), .pd_o(f_pd),
        .rd_byte_o(f_rd), .tmo_set_o(f_tmo)
    );

    assign pins = '{busy: prn_busy, ack_n: prn_ack_n, paper_out: prn_paper_out,
                    online: prn_online, fault_n: prn_fault_n};

    epp_reg_file u_regs (
        .clk_i(clk), .rst_ni(rst_n), .epp_mode_i(cfg_epp_en), .wr_acc_i(wr_acc),
        .rd_acc_i(rd_acc), .ofs_i(ofs), .wdata_i(hst_wdata), .pins_i(pins),
        .tmo_set_i(f_tmo), .epp_byte_i(f_rd), .rdata_o(rf_rdata), .ctrl_o(ctrl),
        .tmo_o(tmo_flag)
    );

    always_comb begin
        hst_rdata      = hit ? rf_rdata : '0;
        pd_out         = f_pd;
        buf_oe_n       = !f_drive;
        buf_dir        = f_drive;
        prn_write_n    = cfg_epp_en ? !f_wr   : !ctrl[0];
        prn_data_stb_n = cfg_epp_en ? !f_dstb : !ctrl[1];
        prn_addr_stb_n = cfg_epp_en ? !f_astb : !ctrl[3];
        prn_init_n     = !ctrl[2];
    end

    // strobe run and gap counters observed on the pins
    logic             epp_stb;
    logic [RUN_W-1:0] run_q;
    logic [GAP_W-1:0] gap_q;

    assign epp_stb = cfg_epp_en && (!prn_data_stb_n || !prn_addr_stb_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            gap_q <= GAP_W'(REC_CYC);
        end else begin
            if (!epp_stb)                     run_q <= '0;
            else if (run_q != RUN_W'(STRB_CYC)) run_q <= run_q + 1'b1;
            if (epp_stb)                      gap_q <= '0;
            else if (gap_q != GAP_W'(REC_CYC)) gap_q <= gap_q + 1'b1;
        end
    end

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(epp_stb) |-> (run_q == RUN_W'(STRB_CYC)));

    // R4
    write_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(epp_stb) && !prn_write_n) |-> $past(!prn_write_n));

    // R7
    read_buf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_stb && prn_write_n) |-> (buf_oe_n && !buf_dir));

    // R10
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(epp_stb) |-> (gap_q == GAP_W'(REC_CYC)));

    // R10
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_stb && hit && acc) |-> !hst_rdy);

endmodule

// File: tb/tb_epp_port_ctrl.sv
module tb_epp_port_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int STRB = 45;
    localparam int REC  = 100;
    localparam int TMO  = 500;

    logic       clk = 0, rst_n = 0;
    logic [1:0] cfg_base_sel = 2'd2;
    logic       cfg_epp_en = 0;
    logic [9:0] hst_addr = '0;
    logic       hst_rd = 0, hst_wr = 0;
    logic [7:0] hst_wdata = '0, hst_rdata;
    logic       hst_rdy;
    logic [7:0] pd_in = '0, pd_out;
    logic       buf_oe_n, buf_dir;
    logic       prn_busy = 0, prn_ack_n = 1, prn_paper_out = 0, prn_online = 1, prn_fault_n = 1;
    logic       prn_write_n, prn_data_stb_n, prn_addr_stb_n, prn_init_n;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    epp_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_base_sel(cfg_base_sel), .cfg_epp_en(cfg_epp_en),
        .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rdy(hst_rdy), .pd_in(pd_in), .pd_out(pd_out),
        .buf_oe_n(buf_oe_n), .buf_dir(buf_dir), .prn_busy(prn_busy), .prn_ack_n(prn_ack_n),
        .prn_paper_out(prn_paper_out), .prn_online(prn_online), .prn_fault_n(prn_fault_n),
        .prn_write_n(prn_write_n), .prn_data_stb_n(prn_data_stb_n),
        .prn_addr_stb_n(prn_addr_stb_n), .prn_init_n(prn_init_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pin monitor: strobe width, gap, write lead, strobe count
    int  act_cnt = 0, gap_cnt = 1000, last_width = 0, last_gap = 0, stb_starts = 0;
    bit  prev_stb = 0, prev_wr_low = 0, last_lead = 0;
    always @(negedge clk) begin
        bit stb;
        stb = cfg_epp_en && (!prn_data_stb_n || !prn_addr_stb_n);
        if (stb) begin
            if (!prev_stb) begin
                last_gap = gap_cnt; last_lead = prev_wr_low; stb_starts++; act_cnt = 0;
            end
            act_cnt++;
        end else begin
            if (prev_stb) begin last_width = act_cnt; gap_cnt = 0; end
            gap_cnt++;
        end
        prev_stb = stb;
        prev_wr_low = !prn_write_n;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_xfer(input logic [9:0] a, input bit wr, input logic [7:0] d,
                             output logic [7:0] rd, output int waits);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = wr; hst_rd = !wr; waits = 0;
        #1;
        while (!hst_rdy) begin waits++; @(negedge clk); #1; end
        rd = hst_rdata;
        @(posedge clk); #1;
        hst_wr = 0; hst_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "pins", {prn_write_n, prn_data_stb_n, prn_addr_stb_n, prn_init_n}, 4'hF);
        check("R1", "buffer", {buf_oe_n, buf_dir}, 2'b10);
        check("R1", "rdy", hst_rdy, 1);
    endtask

    task automatic t_compat();
        logic [7:0] r; int w;
        host_xfer(10'h37A, 1, 8'h0B, r, w);
        @(negedge clk);
        check("R3", "ctrl pins", {prn_write_n, prn_data_stb_n, prn_init_n, prn_addr_stb_n}, 4'b0010);
        host_xfer(10'h37A, 0, 0, r, w);
        check("R3", "ctrl readback", r, 8'h0B);
        host_xfer(10'h378, 1, 8'h5A, r, w);
        host_xfer(10'h378, 0, 0, r, w);
        check("R3", "data readback", r, 8'h5A);
        prn_busy = 1; prn_ack_n = 0; prn_paper_out = 1; prn_online = 0; prn_fault_n = 1;
        host_xfer(10'h379, 0, 0, r, w);
        check("R3", "status", r, 8'hA8);
        prn_busy = 0; prn_ack_n = 1; prn_paper_out = 0; prn_online = 1;
        host_xfer(10'h37A, 1, 8'h04, r, w);
        @(negedge clk);
        check("R3", "init pin", prn_init_n, 0);
        host_xfer(10'h37A, 1, 8'h00, r, w);
    endtask

    task automatic t_disabled();
        logic [7:0] r; int w;
        cfg_base_sel = 2'd0;
        host_xfer(10'h37A, 1, 8'h0F, r, w);
        check("R2", "disabled waits", w, 0);
        @(negedge clk);
        check("R2", "disabled pins", {prn_write_n, prn_data_stb_n, prn_addr_stb_n, prn_init_n}, 4'hF);
        host_xfer(10'h378, 0, 0, r, w);
        check("R2", "disabled rdata", r, 0);
        cfg_base_sel = 2'd2;
        host_xfer(10'h37A, 0, 0, r, w);
        check("R2", "ctrl untouched", r, 0);
    endtask

    task automatic t_bases();
        logic [7:0] r; int w;
        cfg_base_sel = 2'd1;
        host_xfer(10'h3BC, 1, 8'h3C, r, w);
        host_xfer(10'h3BC, 0, 0, r, w);
        check("R2", "base 3BC", r, 8'h3C);
        cfg_base_sel = 2'd3;
        host_xfer(10'h278, 0, 0, r, w);
        check("R2", "base 278", r, 8'h3C);
        host_xfer(10'h378, 0, 0, r, w);
        check("R2", "miss rdata", r, 0);
        host_xfer(10'h27D, 0, 0, r, w);
        check("R2", "offset 5 miss", r, 0);
        cfg_base_sel = 2'd2;
    endtask

    task automatic t_epp_off();
        logic [7:0] r; int w; int s0;
        s0 = stb_starts;
        host_xfer(10'h37C, 1, 8'h77, r, w);
        check("R11", "waits", w, 0);
        check("R11", "buffer off", buf_oe_n, 1);
        host_xfer(10'h37B, 0, 0, r, w);
        check("R11", "rdata", r, 0);
        idle(3);
        check("R11", "no strobe", stb_starts - s0, 0);
    endtask

    task automatic t_write_then_read();
        logic [7:0] r; int w;
        cfg_epp_en = 1; idle(2);
        fork
            host_xfer(10'h37C, 1, 8'hA5, r, w);
            begin
                wait (!prn_data_stb_n); @(negedge clk);
                check("R7", "buf on in write", {buf_oe_n, buf_dir}, 2'b01);
                check("R4", "pd_out", pd_out, 8'hA5);
                check("R4", "write low", prn_write_n, 0);
            end
        join
        check("R4", "write waits", w, STRB + 2);
        check("R4", "data strobe width", last_width, STRB);
        check("R4", "write leads strobe", last_lead, 1);
        pd_in = 8'hC3;
        fork
            host_xfer(10'h37C, 0, 0, r, w);
            begin
                wait (!prn_data_stb_n); @(negedge clk);
                check("R6", "write high in read", prn_write_n, 1);
                check("R7", "buf off in read", {buf_oe_n, buf_dir}, 2'b10);
            end
        join
        check("R6", "read data", r, 8'hC3);
        check("R10", "read after write waits", w, REC + STRB + 1);
        check("R10", "gap", (last_gap >= REC) ? 1 : 0, 1);
        @(negedge clk);
        check("R7", "buf off in recovery", {buf_oe_n, buf_dir}, 2'b10);
    endtask

    task automatic t_addr_then_status();
        logic [7:0] r; int w;
        bit data_seen = 0;
        idle(REC + 5);
        fork
            host_xfer(10'h37B, 1, 8'h3E, r, w);
            begin
                wait (!prn_addr_stb_n);
                repeat (STRB) begin @(negedge clk); if (!prn_data_stb_n) data_seen = 1; end
            end
        join
        check("R5", "addr strobe width", last_width, STRB);
        check("R5", "data strobe idle", data_seen, 0);
        check("R5", "addr waits", w, STRB + 2);
        host_xfer(10'h379, 0, 0, r, w);
        check("R10", "status held off", w, REC);
    endtask

    task automatic t_busy_stretch();
        logic [7:0] r; int w;
        idle(REC + 5);
        prn_busy = 1;
        fork
            host_xfer(10'h37C, 1, 8'h11, r, w);
            begin
                wait (!prn_data_stb_n);
                repeat (80) @(negedge clk);
                prn_busy = 0;
            end
        join
        check("R8", "stretched width", last_width, 80);
        check("R8", "stretched waits", w, 82);
    endtask

    task automatic t_timeout();
        logic [7:0] r; int w;
        idle(REC + 5);
        prn_busy = 1;
        host_xfer(10'h37C, 0, 0, r, w);
        prn_busy = 0;
        check("R9", "timeout width", last_width, STRB + TMO);
        host_xfer(10'h379, 0, 0, r, w);
        check("R9", "timeout bit set", r, 8'h59);
        host_xfer(10'h379, 0, 0, r, w);
        check("R9", "timeout bit cleared", r, 8'h58);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_compat();
        t_disabled();
        t_bases();
        t_epp_off();
        t_write_then_read();
        t_addr_then_status();
        t_busy_stretch();
        t_timeout();
        idle(5);
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule